// File: doc/BRIEF.md
# I2C Register-Transfer Sequencer

This block runs one complete register-addressed I2C transfer without software help. It drives a status-coded I2C byte engine through that engine's control, data and status registers. A request names a 7-bit target, up to four offset bytes, a byte count, a direction and an optional presence probe. The sequencer issues the START, the address and the offsets, and then either keeps writing or turns the bus around with a repeated START to read. Payload bytes move through valid/ready byte ports.

At each step the sequencer waits for the engine's event flag. It lets the status settle, then compares the status with the one code that step must produce. A wrong code or a missing flag ends the transfer. The first failure is packed into a 32-bit word, and a STOP is still sent afterwards. When the transfer ends, the block reports the result word with a one-cycle `done` pulse. The word is zero on success.

Top module: `i2cseq_top`

## Requirements
- R1: A request is taken only while `req_ready` is high, which is exactly when `busy` is low. `busy` rises on acceptance and falls in the cycle `done` pulses. A request raised while busy is ignored, and the engine sees no register write while the block is idle.
- R2: Control bytes use bit 6 = enable, bit 5 = START, bit 4 = STOP, bit 3 = event flag, bit 2 = ACK. START writes 0x60. A byte send writes the data register and then control 0x40 in the same cycle. A receive writes 0x44 (ACK) or 0x40 (NAK). STOP writes 0x50.
- R3: A write transfer sends START (expects 0x08), then `{target,0}` (expects 0x18), then the offset bytes from the most significant down, then the payload bytes in port order. Each offset and payload byte expects 0x28. The offset count selects the low bytes of `req_offset`.
- R4: A read with one or more offsets sends the write-addressed offset phase as in R3. It then issues a repeated START with no STOP in between (expects 0x10), followed by `{target,1}` (expects 0x40).
- R5: A read with zero offsets sends START (0x08) followed directly by `{target,1}` (0x40).
- R6: Each read byte except the last is ACKed and expects 0x50. The last is NAKed and expects 0x58. Received bytes leave on the read port in order and are held stable until taken.
- R7: Probe mode ignores the offsets and the length. It sends START, then `{target,1}`, then one NAKed receive (0x58), then STOP. It returns zero when every step matched. The received byte is not delivered.
- R8: The status is compared only on the first `tick` after the cycle in which the flag is first seen. It is never compared in that same cycle.
- R9: A status mismatch yields `{0x01, control|0x08, observed status, expected status}`. The control field is the last control byte written.
- R10: If no flag arrives within 1000 ticks, the result is `{0x02, control, status seen at expiry, expected status}`. The control field has bit 3 clear.
- R11: STOP is written after every transfer, including failed ones. The result is the first failure whenever one occurred.
- R12: After STOP, the block waits for status 0xF8. If 0xF8 does not appear within 1000 ticks, the result is `{0x02, 0x50, status, 0xF8}`, unless an earlier failure already took precedence.
- R13: A zero-length write sends only START, the address and the offsets, and then STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe per bus time unit |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_target | input | 7 | Target address |
| req_offset | input | 32 | Offset bytes, low bytes used |
| req_off_cnt | input | 3 | Number of offset bytes, 0 to 4 |
| req_len | input | 8 | Payload byte count |
| req_read | input | 1 | 1 = read, 0 = write |
| req_probe | input | 1 | Presence probe mode |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Result valid pulse |
| result | output | 32 | Zero or packed error word |
| wr_valid | input | 1 | Write payload byte available |
| wr_ready | output | 1 | Write payload byte taken |
| wr_byte | input | 8 | Write payload byte |
| rd_valid | output | 1 | Received byte available |
| rd_ready | input | 1 | Received byte taken |
| rd_byte | output | 8 | Received byte |
| eng_ctrl_we | output | 1 | Engine control register write |
| eng_ctrl | output | 8 | Engine control value |
| eng_data_we | output | 1 | Engine data register write |
| eng_data | output | 8 | Engine data value |
| eng_flag | input | 1 | Engine event flag |
| eng_status | input | 8 | Engine status code |
| eng_rdata | input | 8 | Engine received byte |

## Verification
A wrong step pointer or offset counter shows up at the ports within one byte time. The engine log then records a misordered address or offset byte, a missing repeated START, or a spurious STOP. It also shows as a nonzero result whose expected-status field names the step the sequencer believed it was on. A wrong read counter shows at once as an ACK/NAK control byte on the wrong receive, and as a surplus or missing byte on the read port. A status compared too early is caught by an engine model whose status lags its flag by a cycle, which turns every step into a class-0x01 failure. Timer faults show after about 1000 ticks as a timeout word with the wrong class or fields.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

    localparam logic [7:0] CTL_ACK   = 8'h04;
    localparam logic [7:0] CTL_FLAG  = 8'h08;
    localparam logic [7:0] CTL_STOP  = 8'h10;
    localparam logic [7:0] CTL_START = 8'h20;
    localparam logic [7:0] CTL_EN    = 8'h40;

    localparam logic [7:0] SC_START   = 8'h08;
    localparam logic [7:0] SC_RESTART = 8'h10;
    localparam logic [7:0] SC_AW_ACK  = 8'h18;
    localparam logic [7:0] SC_DW_ACK  = 8'h28;
    localparam logic [7:0] SC_AR_ACK  = 8'h40;
    localparam logic [7:0] SC_DR_ACK  = 8'h50;
    localparam logic [7:0] SC_DR_NAK  = 8'h58;
    localparam logic [7:0] SC_IDLE    = 8'hF8;

    localparam logic [7:0] CLS_STATUS  = 8'h01;
    localparam logic [7:0] CLS_TIMEOUT = 8'h02;

    typedef enum logic [2:0] {
        S_IDLE, S_ISSUE, S_WAIT, S_SETTLE, S_WBYTE, S_RBYTE, S_STOP, S_STOPWAIT
    } seq_state_e;

    typedef enum logic [2:0] {
        K_START, K_RSTART, K_ADDR, K_OFF, K_WDATA, K_RDATA
    } step_e;

    function automatic logic [31:0] pack_err(input logic [7:0] cls, input logic [7:0] ctl,
                                             input logic [7:0] sts, input logic [7:0] exp);
        return {cls, ctl, sts, exp};
    endfunction

endpackage

// File: rtl/i2cseq_expect.sv
module i2cseq_expect
    import i2cseq_pkg::*;
(
    input  step_e       step,
    input  logic        rd_addr,
    input  logic        more,
    output logic [7:0]  exp_code
);
    always_comb begin
        case (step)
            K_START:  exp_code = SC_START;
            K_RSTART: exp_code = SC_RESTART;
            K_ADDR:   exp_code = rd_addr ? SC_AR_ACK : SC_AW_ACK;
            K_RDATA:  exp_code = more ? SC_DR_ACK : SC_DR_NAK;
            default:  exp_code = SC_DW_ACK;
        endcase
    end
endmodule

// File: rtl/i2cseq_timer.sv
module i2cseq_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign expired = run && tick && (cnt_q == CW'(LIMIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (!run)
            cnt_d = '0;
        else if (tick && !expired)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2cseq_top.sv
module i2cseq_top
    import i2cseq_pkg::*;
#(
    parameter int LEN_W         = 8,
    parameter int OFF_BYTES     = 4,
    parameter int TIMEOUT_TICKS = 1000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [6:0]             req_target,
    input  logic [OFF_BYTES*8-1:0] req_offset,
    input  logic [$clog2(OFF_BYTES+1)-1:0] req_off_cnt,
    input  logic [LEN_W-1:0]       req_len,
    input  logic                   req_read,
    input  logic                   req_probe,
    output logic                   busy,
    output logic                   done,
    output logic [31:0]            result,
    input  logic                   wr_valid,
    output logic                   wr_ready,
    input  logic [7:0]             wr_byte,
    output logic                   rd_valid,
    input  logic                   rd_ready,
    output logic [7:0]             rd_byte,
    output logic                   eng_ctrl_we,
    output logic [7:0]             eng_ctrl,
    output logic                   eng_data_we,
    output logic [7:0]             eng_data,
    input  logic                   eng_flag,
    input  logic [7:0]             eng_status,
    input  logic [7:0]             eng_rdata
);
    localparam int OFF_W = OFF_BYTES * 8;
    localparam int OC_W  = $clog2(OFF_BYTES + 1);

    typedef struct packed {
        seq_state_e        state;
        step_e             step;
        logic [6:0]        target;
        logic [OFF_W-1:0]  offset;
        logic [OC_W-1:0]   off_cnt;
        logic [LEN_W-1:0]  cnt;
        logic              read;
        logic              probe;
        logic              rdir;
        logic [7:0]        ctrl;
        logic [7:0]        data;
        logic [31:0]       err;
        logic              err_set;
        logic              done;
        logic [31:0]       result;
    } regs_t;

    regs_t q, d;
    logic [7:0] exp_code;
    logic       expired;
    logic       timer_run;

    i2cseq_expect u_expect (
        .step     (q.step),
        .rd_addr  (q.rdir),
        .more     (q.cnt > LEN_W'(1)),
        .exp_code (exp_code)
    );

    assign timer_run = (q.state == S_WAIT) || (q.state == S_STOPWAIT);

    i2cseq_timer #(.LIMIT(TIMEOUT_TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (timer_run),
        .tick    (tick),
        .expired (expired)
    );

    // Next action once the write-addressed part has reached an offset boundary
    function automatic regs_t after_write_phase(input regs_t r);
        regs_t n;
        int    idx;
        n = r;
        if (r.off_cnt != '0) begin
            idx     = int'(r.off_cnt) - 1;
            n.step  = K_OFF;
            n.data  = r.offset[8*idx +: 8];
            n.ctrl  = CTL_EN;
            n.state = S_ISSUE;
        end else if (r.read) begin
            n.step  = K_RSTART;
            n.ctrl  = CTL_EN | CTL_START;
            n.state = S_ISSUE;
        end else if (r.cnt != '0) begin
            n.state = S_WBYTE;
        end else begin
            n.state = S_STOP;
        end
        return n;
    endfunction

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.state)
            S_IDLE: begin
                if (req_valid) begin
                    d.state   = S_ISSUE;
                    d.step    = K_START;
                    d.ctrl    = CTL_EN | CTL_START;
                    d.target  = req_target;
                    d.offset  = req_offset;
                    d.off_cnt = req_probe ? '0 : req_off_cnt;
                    d.cnt     = req_probe ? LEN_W'(1) : req_len;
                    d.read    = req_read | req_probe;
                    d.probe   = req_probe;
                    d.rdir    = 1'b0;
                    d.err     = '0;
                    d.err_set = 1'b0;
                end
            end
            S_ISSUE: d.state = S_WAIT;
            S_WAIT: begin
                if (eng_flag) begin
                    d.state = S_SETTLE;
                end else if (expired) begin
                    d.err     = pack_err(CLS_TIMEOUT, q.ctrl, eng_status, exp_code);
                    d.err_set = 1'b1;
                    d.state   = S_STOP;
                end
            end
            S_SETTLE: begin
                if (tick) begin
                    if (eng_status != exp_code) begin
                        d.err     = pack_err(CLS_STATUS, q.ctrl | CTL_FLAG, eng_status, exp_code);
                        d.err_set = 1'b1;
                        d.state   = S_STOP;
                    end else begin
                        case (q.step)
                            K_START: begin
                                d.rdir  = q.probe || (q.read && q.off_cnt == '0);
                                d.data  = {q.target, d.rdir};
                                d.step  = K_ADDR;
                                d.ctrl  = CTL_EN;
                                d.state = S_ISSUE;
                            end
                            K_RSTART: begin
                                d.rdir  = 1'b1;
                                d.data  = {q.target, 1'b1};
                                d.step  = K_ADDR;
                                d.ctrl  = CTL_EN;
                                d.state = S_ISSUE;
                            end
                            K_ADDR: begin
                                if (!q.rdir) begin
                                    d = after_write_phase(q);
                                end else if (q.cnt != '0) begin
                                    d.step  = K_RDATA;
                                    d.ctrl  = CTL_EN | ((q.cnt > LEN_W'(1)) ? CTL_ACK : 8'h00);
                                    d.state = S_ISSUE;
                                end else begin
                                    d.state = S_STOP;
                                end
                            end
                            K_OFF: begin
                                d.off_cnt = q.off_cnt - 1'b1;
                                d = after_write_phase(d);
                            end
                            K_WDATA: d.state = (q.cnt != '0) ? S_WBYTE : S_STOP;
                            default: begin
                                d.data  = eng_rdata;
                                d.state = q.probe ? S_STOP : S_RBYTE;
                            end
                        endcase
                    end
                end
            end
            S_WBYTE: begin
                if (wr_valid) begin
                    d.data  = wr_byte;
                    d.cnt   = q.cnt - LEN_W'(1);
                    d.step  = K_WDATA;
                    d.ctrl  = CTL_EN;
                    d.state = S_ISSUE;
                end
            end
            S_RBYTE: begin
                if (rd_ready) begin
                    d.cnt = q.cnt - LEN_W'(1);
                    if (d.cnt != '0) begin
                        d.step  = K_RDATA;
                        d.ctrl  = CTL_EN | ((d.cnt > LEN_W'(1)) ? CTL_ACK : 8'h00);
                        d.state = S_ISSUE;
                    end else begin
                        d.state = S_STOP;
                    end
                end
            end
            S_STOP: begin
                d.ctrl  = CTL_EN | CTL_STOP;
                d.state = S_STOPWAIT;
            end
            default: begin
                if (eng_status == SC_IDLE) begin
                    d.done   = 1'b1;
                    d.result = q.err_set ? q.err : 32'h0;
                    d.state  = S_IDLE;
                end else if (expired) begin
                    d.done   = 1'b1;
                    d.result = q.err_set ? q.err
                                         : pack_err(CLS_TIMEOUT, q.ctrl, eng_status, SC_IDLE);
                    d.state  = S_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= S_IDLE;
            q.step  <= K_START;
        end else begin
            q <= d;
        end
    end

    assign req_ready   = (q.state == S_IDLE);
    assign busy        = (q.state != S_IDLE);
    assign done        = q.done;
    assign result      = q.result;
    assign wr_ready    = (q.state == S_WBYTE);
    assign rd_valid    = (q.state == S_RBYTE);
    assign rd_byte     = q.data;
    assign eng_ctrl_we = (q.state == S_ISSUE) || (q.state == S_STOP);
    assign eng_ctrl    = (q.state == S_STOP) ? (CTL_EN | CTL_STOP) : q.ctrl;
    assign eng_data_we = (q.state == S_ISSUE) &&
                         (q.step == K_ADDR || q.step == K_OFF || q.step == K_WDATA);
    assign eng_data    = q.data;

endmodule

// File: rtl/i2cseq_checker.sv
module i2cseq_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        busy,
    input logic        done,
    input logic [31:0] result,
    input logic        rd_valid,
    input logic        rd_ready,
    input logic [7:0]  rd_byte,
    input logic        eng_ctrl_we,
    input logic [7:0]  eng_ctrl,
    input logic        eng_data_we
);
    logic stop_seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            stop_seen_q <= 1'b0;
        else if (req_valid && req_ready)
            stop_seen_q <= 1'b0;
        else if (eng_ctrl_we && eng_ctrl[4])
            stop_seen_q <= 1'b1;
    end

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));                                     // R1
    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!eng_ctrl_we && !eng_data_we));                            // R1
    AST_STOP_BEFORE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> stop_seen_q);                                                // R11
    AST_ERR_CLASS_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result != 32'h0) |-> (result[31:24] == 8'h01 || result[31:24] == 8'h02)); // R9
    AST_MISMATCH_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result[31:24] == 8'h01) |-> result[19]);                     // R9
    AST_TIMEOUT_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result[31:24] == 8'h02) |-> !result[19]);                    // R10
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_byte)));          // R6
endmodule

bind i2cseq_top i2cseq_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .busy        (busy),
    .done        (done),
    .result      (result),
    .rd_valid    (rd_valid),
    .rd_ready    (rd_ready),
    .rd_byte     (rd_byte),
    .eng_ctrl_we (eng_ctrl_we),
    .eng_ctrl    (eng_ctrl),
    .eng_data_we (eng_data_we)
);

// File: tb/i2cseq_top_bench.sv
module i2cseq_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [6:0]  req_target = '0;
    logic [31:0] req_offset = '0;
    logic [2:0]  req_off_cnt = '0;
    logic [7:0]  req_len = '0;
    logic        req_read = 1'b0;
    logic        req_probe = 1'b0;
    logic        busy, done;
    logic [31:0] result;
    logic        wr_valid, wr_ready;
    logic [7:0]  wr_byte;
    logic        rd_valid, rd_ready;
    logic [7:0]  rd_byte;
    logic        eng_ctrl_we, eng_data_we;
    logic [7:0]  eng_ctrl, eng_data;
    logic        m_flag;
    logic [7:0]  m_status, m_rdata;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    // per-transfer scenario, written only by the initial block
    int cur_len = 0;
    int inj_step = -1;
    int inj_kind = 0;
    bit stop_hang = 0;

    i2cseq_top u_i2cseq_top (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .req_valid(req_valid), .req_ready(req_ready), .req_target(req_target),
        .req_offset(req_offset), .req_off_cnt(req_off_cnt), .req_len(req_len),
        .req_read(req_read), .req_probe(req_probe),
        .busy(busy), .done(done), .result(result),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_byte(wr_byte),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_byte(rd_byte),
        .eng_ctrl_we(eng_ctrl_we), .eng_ctrl(eng_ctrl),
        .eng_data_we(eng_data_we), .eng_data(eng_data),
        .eng_flag(m_flag), .eng_status(m_status), .eng_rdata(m_rdata)
    );

    always #5 clk = ~clk;

    always @(posedge clk) tick <= rst_n ? ~tick : 1'b0;

    // ---------------- byte engine model ----------------
    logic [7:0] m_pend_st, m_pend_rd;
    logic       m_upd, m_started, m_addr_next;
    int         m_pend, m_spend, m_step, m_rx, m_nlog, m_nctl;
    logic [7:0] m_blog [0:31];
    logic [7:0] m_clog [0:31];
    int         w_idx, r_n;
    logic [7:0] r_log [0:31];

    wire accept = req_valid && req_ready;
    assign wr_valid = (w_idx < cur_len);
    assign wr_byte  = 8'h50 + 8'(w_idx);
    assign rd_ready = tick;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_flag <= 1'b0; m_status <= 8'hF8; m_rdata <= 8'h00;
            m_upd <= 1'b0; m_started <= 1'b0; m_addr_next <= 1'b0;
            m_pend <= 0; m_spend <= 0; m_step <= 0; m_rx <= 0;
            m_nlog <= 0; m_nctl <= 0; w_idx <= 0; r_n <= 0;
        end else begin
            if (accept) begin
                m_nlog <= 0; m_nctl <= 0; m_rx <= 0; w_idx <= 0; r_n <= 0;
            end
            if (wr_valid && wr_ready) w_idx <= w_idx + 1;
            if (rd_valid && rd_ready) begin
                r_log[r_n] <= rd_byte;
                r_n <= r_n + 1;
            end
            if (m_pend > 0) begin
                m_pend <= m_pend - 1;
                if (m_pend == 1) begin m_flag <= 1'b1; m_upd <= 1'b1; end
            end
            if (m_upd) begin
                // status lags the flag by one clock
                m_status <= m_pend_st; m_rdata <= m_pend_rd; m_upd <= 1'b0;
            end
            if (m_spend > 0) begin
                m_spend <= m_spend - 1;
                if (m_spend == 1 && !stop_hang) m_status <= 8'hF8;
            end
            if (eng_ctrl_we) begin
                logic [7:0] resp, rdv;
                m_clog[m_nctl] <= eng_ctrl;
                m_nctl <= m_nctl + 1;
                m_flag <= 1'b0;
                if (eng_ctrl[4]) begin
                    m_spend <= 3; m_started <= 1'b0; m_addr_next <= 1'b0; m_step <= 0; m_pend <= 0;
                end else begin
                    rdv = 8'h00;
                    if (eng_ctrl[5]) begin
                        resp = m_started ? 8'h10 : 8'h08;
                        m_started <= 1'b1; m_addr_next <= 1'b1;
                    end else if (eng_data_we) begin
                        m_blog[m_nlog] <= eng_data;
                        m_nlog <= m_nlog + 1;
                        resp = m_addr_next ? (eng_data[0] ? 8'h40 : 8'h18) : 8'h28;
                        m_addr_next <= 1'b0;
                    end else begin
                        resp = eng_ctrl[2] ? 8'h50 : 8'h58;
                        rdv  = 8'hA0 + 8'(m_rx);
                        m_rx <= m_rx + 1;
                    end
                    if (m_step == inj_step && inj_kind == 1) resp = 8'h30;
                    m_pend_st <= resp;
                    m_pend_rd <= rdv;
                    m_pend <= (m_step == inj_step && inj_kind == 2) ? 0 : 3;
                    m_step <= m_step + 1;
                end
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 195000 && !finished) begin
            errors++;
            $display("FAIL watchdog expired actual %0d expected < 195000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    logic [7:0] e_ctl [0:31];
    logic [7:0] e_ex  [0:31];
    logic [7:0] e_byte[0:31];
    int e_n, e_nb;

    task automatic add_step(input logic [7:0] c, input logic [7:0] x);
        e_ctl[e_n] = c; e_ex[e_n] = x; e_n++;
    endtask

    task automatic add_rdata(input int len);
        for (int i = 0; i < len; i++)
            add_step((len - i > 1) ? 8'h44 : 8'h40, (len - i > 1) ? 8'h50 : 8'h58);
    endtask

    task automatic run(input logic [6:0] t, input logic [31:0] off, input int ocnt,
                       input int len, input bit rd, input bit pr,
                       input int ik, input int is, input bit hang, input bit poke,
                       input string req);
        logic [31:0] exp_res;
        int ncl, k, guard;
        bit got;
        e_n = 0; e_nb = 0;
        add_step(8'h60, 8'h08);
        if (pr) begin
            e_byte[e_nb++] = {t, 1'b1};
            add_step(8'h40, 8'h40);
            add_step(8'h40, 8'h58);
        end else if (rd && ocnt == 0) begin
            e_byte[e_nb++] = {t, 1'b1};
            add_step(8'h40, 8'h40);
            add_rdata(len);
        end else begin
            e_byte[e_nb++] = {t, 1'b0};
            add_step(8'h40, 8'h18);
            for (int i = ocnt - 1; i >= 0; i--) begin
                e_byte[e_nb++] = off[8*i +: 8];
                add_step(8'h40, 8'h28);
            end
            if (rd) begin
                add_step(8'h60, 8'h10);
                e_byte[e_nb++] = {t, 1'b1};
                add_step(8'h40, 8'h40);
                add_rdata(len);
            end else begin
                for (int i = 0; i < len; i++) begin
                    e_byte[e_nb++] = 8'h50 + 8'(i);
                    add_step(8'h40, 8'h28);
                end
            end
        end
        ncl = e_n;
        if (ik != 0 && is < e_n) begin
            k = is;
            ncl = k + 1;
            if (ik == 1) exp_res = {8'h01, e_ctl[k] | 8'h08, 8'h30, e_ex[k]};
            else         exp_res = {8'h02, e_ctl[k], (k == 0) ? 8'hF8 : e_ex[k-1], e_ex[k]};
        end else if (hang) begin
            exp_res = {8'h02, 8'h50, e_ex[e_n-1], 8'hF8};
        end else begin
            exp_res = 32'h0;
        end

        @(negedge clk);
        cur_len = (rd || pr) ? 0 : len;
        inj_kind = ik; inj_step = is; stop_hang = hang;
        req_target = t; req_offset = off; req_off_cnt = 3'(ocnt); req_len = 8'(len);
        req_read = rd; req_probe = pr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy && !req_ready, "R1", "busy after accept", {busy, req_ready}, 2'b10);
        if (poke) begin
            @(negedge clk);
            req_target = 7'h7F; req_read = ~rd; req_valid = 1'b1;
            chk(!req_ready, "R1", "ready while busy", req_ready, 0);
            @(negedge clk);
            req_valid = 1'b0;
        end
        got = 0;
        guard = 0;
        while (!got && guard < 8000) begin
            if (done) got = 1;
            else begin @(negedge clk); guard++; end
        end
        chk(got, req, "done seen", got, 1);
        chk(result === exp_res, req, "result word", result, exp_res);
        @(negedge clk);
        chk(!busy && req_ready, "R1", "idle after done", busy, 0);
        // control sequence, STOP last (R2, R11)
        chk(m_nctl == ncl + 1, "R11", "control write count", m_nctl, ncl + 1);
        if (m_nctl == ncl + 1) begin
            for (int i = 0; i < ncl; i++)
                chk(m_clog[i] == e_ctl[i], "R2", "control byte", m_clog[i], e_ctl[i]);
            chk(m_clog[ncl] == 8'h50, "R11", "stop control", m_clog[ncl], 8'h50);
        end
        if (ik == 0) begin
            chk(m_nlog == e_nb, req, "bytes sent", m_nlog, e_nb);
            if (m_nlog == e_nb)
                for (int i = 0; i < e_nb; i++)
                    chk(m_blog[i] == e_byte[i], req, "byte order", m_blog[i], e_byte[i]);
            chk(r_n == ((rd && !pr) ? len : 0), "R6", "bytes delivered", r_n, (rd && !pr) ? len : 0);
            if (rd && !pr && r_n == len)
                for (int i = 0; i < len; i++)
                    chk(r_log[i] == 8'hA0 + 8'(i), "R6", "read data", r_log[i], 8'hA0 + 8'(i));
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && req_ready && !done && result == 0, "R1", "reset state", {busy, req_ready, done}, 3'b010);

        // R3 / R13: writes over all offset counts and short lengths
        for (int oc = 0; oc <= 4; oc++)
            for (int ln = 0; ln <= 3; ln++)
                run(7'h2A + 7'(oc), 32'hC4B3A291, oc, ln, 0, 0, 0, -1, 0, 0, (ln == 0) ? "R13" : "R3");
        // R4 / R5 / R6: reads over all offset counts and short lengths
        for (int oc = 0; oc <= 4; oc++)
            for (int ln = 0; ln <= 3; ln++)
                run(7'h51 - 7'(oc), 32'h1E2D3C4B, oc, ln, 1, 0, 0, -1, 0, 0, (oc == 0) ? "R5" : "R4");
        // R7: probe ignores offset and length
        run(7'h3C, 32'hFFFF_FFFF, 3, 5, 0, 1, 0, -1, 0, 0, "R7");
        run(7'h01, 32'h0, 0, 0, 1, 1, 0, -1, 0, 1, "R7");
        // R9 / R8: mismatch at every step of a write and a read
        for (int s = 0; s < 6; s++) run(7'h22, 32'h0000_9876, 2, 2, 0, 0, 1, s, 0, 0, "R9");
        for (int s = 0; s < 7; s++) run(7'h33, 32'h0000_00E7, 1, 2, 1, 0, 1, s, 0, 0, "R9");
        run(7'h44, 32'h0, 0, 0, 0, 1, 1, 1, 0, 0, "R7");
        // R10: missing flag on first step and mid transfer
        run(7'h55, 32'h0000_1234, 2, 2, 0, 0, 2, 0, 0, 0, "R10");
        run(7'h55, 32'h0000_1234, 2, 2, 0, 0, 2, 3, 0, 0, "R10");
        // R11: first failure wins over a hung STOP
        run(7'h66, 32'h0000_00AB, 1, 1, 0, 0, 1, 2, 1, 0, "R11");
        // R12: STOP never reaches idle
        run(7'h77, 32'h0000_00CD, 1, 2, 1, 0, 0, -1, 1, 0, "R12");
        stop_hang = 0;
        // R8: ordinary transfer after the hang with status lagging the flag
        run(7'h12, 32'h0000_5566, 2, 3, 1, 0, 0, -1, 0, 1, "R8");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule